// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This block produces the single interrupt line of a UART whose transmit and receive queues are 32 entries deep and may be switched off. It watches three sources: room in the transmit queue, data waiting in the receive queue, and any edge on the clear-to-send (CTS) input. Each source has a sticky raw flag. Software selects which flags may reach the interrupt line, reads the raw and the masked flags, and drops flags by writing ones to a clear register.

With the queues on, the transmit and receive thresholds are set in eighths of the queue depth. The transmit threshold is compared against free space and the receive threshold against the fill count. With the queues off, the single holding buffers decide. An empty output buffer raises the transmit source, and a full input buffer raises the receive source. The bus is a plain select/write port with a combinational read path.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable, raw, level and config registers read 0, so the queues are off, and `irq` is 0.
- R2: The enable register (address 1) holds 3 bits: bit 0 transmit, bit 1 receive, bit 2 CTS. A 1 lets that source through.
- R3: Address 2 reads the raw flags and address 3 reads the raw flags ANDed with the enable bits, with the same bit order.
- R4: `irq` is high exactly when at least one masked flag is high.
- R5: A raw flag stays set after its condition ends, until a write to address 4 carries a 1 in that bit. Zero bits in that write have no effect.
- R6: A clear write does not drop a flag whose condition still holds in that cycle.
- R7: A rising or falling CTS edge sets raw bit 2. The input passes two synchronizing flops, so the flag appears on the third clock edge after the change.
- R8: With the queues on, the receive condition is `rx_count` at or above the receive threshold.
- R9: With the queues on, the transmit condition is DEPTH minus `tx_count` at or above the transmit threshold.
- R10: The level register (address 5) holds the receive code in bits 2:0 and the transmit code in bits 5:3. Codes 0, 1, 2, 3 and 4 give 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH. Codes 5 to 7 act as 7/8.
- R11: With the queues off (bit 0 of address 6 is 0), the transmit condition is `tx_hold_empty` and the receive condition is `rx_hold_full`. The counts are ignored.
- R12: Address 4 reads as 0, and register bits beyond those defined read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high with `bus_sel` |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rx_count | input | 6 | Receive queue fill count |
| tx_count | input | 6 | Transmit queue fill count |
| rx_hold_full | input | 1 | Receive holding buffer full (queues off) |
| tx_hold_empty | input | 1 | Transmit holding buffer empty (queues off) |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default depth of 32, so every threshold can be reached: 4, 8, 16, 24 and 28 entries. Each code is walked with the count one below the threshold and then exactly at it. The full and empty queue ends are also in range with a 6-bit count. This lets the reserved codes be shown to alias to 7/8. The transmit free-space arithmetic is checked at both edges of each threshold.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants for the UART interrupt unit.
// Assumes a 3-bit address space and byte-wide registers.
package uart_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NSRC   = 3;

    // Source bit positions inside the raw, enable and masked registers
    localparam int SRC_TX  = 0;
    localparam int SRC_RX  = 1;
    localparam int SRC_CTS = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] A_RAW    = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASKED = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CONFIG = 3'd6;
endpackage

// File: rtl/uart_irq_cts_edge.sv
// Module: brings the asynchronous CTS input into the clock domain through
// two flops and flags every change of the synchronized value for one cycle.
// Assumes cts_in is low during reset, or that one flag after reset is acceptable.
module uart_irq_cts_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_in,
    output logic cts_chg
);
    logic s1, s2, s3;

    // Synchronizer chain plus a delayed copy for the comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= cts_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // A difference between the two stages marks an edge
    assign cts_chg = s2 ^ s3;

    // R7: an edge flag lasts one cycle unless the input moves again
    assert_chg_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cts_chg && $stable(s1) |=> !cts_chg);
endmodule

// File: rtl/uart_irq_trigger.sv
// Module: decides whether one queue direction requests service.
// Queue mode compares the fill count (receive) or the free space (transmit)
// with a threshold in eighths of DEPTH. Without queues a holding-buffer flag decides.
// Assumes count never exceeds DEPTH.
module uart_irq_trigger #(
    parameter int DEPTH = 32,
    parameter bit IS_TX = 1'b0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [2:0]       level,
    input  logic [CNT_W-1:0] count,
    input  logic             hold_flag,
    output logic             cond
);
    localparam logic [CNT_W-1:0] T1 = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] T2 = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] T4 = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] T6 = CNT_W'((DEPTH * 3) / 4);
    localparam logic [CNT_W-1:0] T7 = CNT_W'((DEPTH * 7) / 8);

    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] metric;

    // Translate the level code into an entry count
    always_comb begin
        case (level)
            3'd0:    thr = T1;
            3'd1:    thr = T2;
            3'd2:    thr = T4;
            3'd3:    thr = T6;
            default: thr = T7;
        endcase
    end

    // Pick the quantity compared against the threshold
    generate
        if (IS_TX) begin : g_free
            assign metric = CNT_W'(DEPTH) - count;
        end else begin : g_fill
            assign metric = count;
        end
    endgenerate

    // Choose between queue mode and holding-buffer mode
    always_comb begin
        cond = fifo_en ? (metric >= thr) : hold_flag;
    end

    // R8/R9: an empty receive queue or a full transmit queue never asks for service
    generate
        if (IS_TX) begin : g_tx_chk
            assert_tx_full_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
                fifo_en && (count == CNT_W'(DEPTH)) |-> !cond);
        end else begin : g_rx_chk
            assert_rx_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
                fifo_en && (count == '0) |-> !cond);
        end
    endgenerate
endmodule

// File: rtl/uart_irq_regs.sv
// Module: register file of the interrupt unit. It holds the enable, level and
// config registers and the sticky raw flags, handles clear writes and drives the read mux.
// Assumes one access per cycle and a combinational read.
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_cond,
    output logic [NSRC-1:0]   raw,
    output logic [NSRC-1:0]   enable,
    output logic [2:0]        rx_level,
    output logic [2:0]        tx_level,
    output logic              fifo_en
);
    logic            wr_hit;
    logic [NSRC-1:0] clr_hit;
    logic [NSRC-1:0] masked;
    logic [1:0]      unused_wdata_hi;

    assign wr_hit          = bus_sel && bus_wr;
    assign unused_wdata_hi = bus_wdata[7:6];
    assign masked          = raw & enable;

    // Bits named by a clear write
    always_comb begin
        clr_hit = (wr_hit && bus_addr == A_CLEAR) ? bus_wdata[NSRC-1:0] : '0;
    end

    // Software-written control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= '0;
            rx_level <= 3'd0;
            tx_level <= 3'd0;
            fifo_en  <= 1'b0;
        end else if (wr_hit) begin
            if (bus_addr == A_ENABLE) enable <= bus_wdata[NSRC-1:0];
            if (bus_addr == A_LEVEL) begin
                rx_level <= bus_wdata[2:0];
                tx_level <= bus_wdata[5:3];
            end
            if (bus_addr == A_CONFIG) fifo_en <= bus_wdata[0];
        end
    end

    // Sticky raw flags; a live condition wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_hit) | src_cond;
    end

    // Read mux, undefined bits return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata[NSRC-1:0] = enable;
            A_RAW:    bus_rdata[NSRC-1:0] = raw;
            A_MASKED: bus_rdata[NSRC-1:0] = masked;
            A_LEVEL:  bus_rdata[5:0]      = {tx_level, rx_level};
            A_CONFIG: bus_rdata[0]        = fifo_en;
            default:  bus_rdata           = '0;
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_chk
            // R5: a set flag survives any cycle without a matching clear
            assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
                raw[gi] && !clr_hit[gi] |=> raw[gi]);
            // R6: a live condition leaves the flag set next cycle, clear or not
            assert_cond_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
                src_cond[gi] |=> raw[gi]);
            // R5: a flag only drops after a clear with no live condition
            assert_drop_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(raw[gi]) |-> $past(clr_hit[gi]) && !$past(src_cond[gi]));
        end
    endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: top of the UART interrupt unit. It joins the CTS edge detector, the
// two queue triggers and the register file, and ORs the masked flags onto irq.
// Assumes counts are stable in the clock domain and cts_in may be asynchronous.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              rx_hold_full,
    input  logic              tx_hold_empty,
    input  logic              cts_in,
    output logic              irq
);
    logic [NSRC-1:0] src_cond;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] enable;
    logic [2:0]      rx_level, tx_level;
    logic            fifo_en;

    uart_irq_cts_edge u_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_in  (cts_in),
        .cts_chg (src_cond[SRC_CTS])
    );

    uart_irq_trigger #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .level     (tx_level),
        .count     (tx_count),
        .hold_flag (tx_hold_empty),
        .cond      (src_cond[SRC_TX])
    );

    uart_irq_trigger #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .level     (rx_level),
        .count     (rx_count),
        .hold_flag (rx_hold_full),
        .cond      (src_cond[SRC_RX])
    );

    uart_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_cond  (src_cond),
        .raw       (raw),
        .enable    (enable),
        .rx_level  (rx_level),
        .tx_level  (tx_level),
        .fifo_en   (fifo_en)
    );

    // Combine every enabled, active source onto the single line
    always_comb begin
        irq = |(raw & enable);
    end

    // R4: with every source disabled the line stays low
    assert_quiet_when_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
    // R4: the line never rises without some raw flag behind it
    assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0));
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
    localparam int DEPTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
    logic             rx_hold_full = 1'b0, tx_hold_empty = 1'b0, cts_in = 1'b0;
    logic             irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    uart_irq_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_count(rx_count), .tx_count(tx_count), .rx_hold_full(rx_hold_full),
        .tx_hold_empty(tx_hold_empty), .cts_in(cts_in), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr = a; #1; v = int'(bus_rdata);
    endtask

    function automatic int thr_of(input int code);
        case (code)
            0: return DEPTH / 8;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            3: return (DEPTH * 3) / 4;
            default: return (DEPTH * 7) / 8;
        endcase
    endfunction

    task automatic t_reset;
        int v;
        rd(3'd1, v); check("R1 enable", v, 0);
        rd(3'd2, v); check("R1 raw", v, 0);
        rd(3'd5, v); check("R1 level", v, 0);
        rd(3'd6, v); check("R1 config", v, 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_holding_mode;
        int v;
        rx_count = 6'(DEPTH); tx_count = '0;
        tick(1);
        rd(3'd2, v); check("R11 counts ignored with queues off", v, 0);
        tx_hold_empty = 1'b1; tick(1);
        rd(3'd2, v); check("R11 tx from holding empty", v, 1);
        rx_hold_full = 1'b1; tick(1);
        rd(3'd2, v); check("R11 rx from holding full", v, 3);
        wr(3'd4, 8'h03);
        rd(3'd2, v); check("R6 clear ignored while live", v, 3);
        tx_hold_empty = 1'b0; rx_hold_full = 1'b0; tick(2);
        rd(3'd2, v); check("R5 sticky after condition ends", v, 3);
        wr(3'd4, 8'h00);
        rd(3'd2, v); check("R5 zero clear bits no effect", v, 3);
        wr(3'd4, 8'h02);
        rd(3'd2, v); check("R5 clear one bit", v, 1);
        wr(3'd4, 8'h01);
        rd(3'd2, v); check("R5 clear other bit", v, 0);
        rx_count = '0;
    endtask

    task automatic t_mask;
        int v;
        tx_hold_empty = 1'b1; tick(1); tx_hold_empty = 1'b0; tick(1);
        rd(3'd3, v); check("R3 masked zero with enable 0", v, 0);
        check("R4 irq low when masked", int'(irq), 0);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check("R12 enable upper bits read 0", v, 7);
        wr(3'd1, 8'h01);
        rd(3'd2, v); check("R3 raw read", v, 1);
        rd(3'd3, v); check("R3 masked read", v, 1);
        check("R2 R4 irq when enabled", int'(irq), 1);
        wr(3'd1, 8'h06);
        check("R2 irq low when bit disabled", int'(irq), 0);
        rd(3'd4, v); check("R12 clear reads 0", v, 0);
        wr(3'd4, 8'h07);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_rx_levels;
        int v, t;
        wr(3'd6, 8'h01);
        tx_count = 6'(DEPTH);
        for (int k = 0; k < 8; k++) begin
            t = thr_of(k);
            wr(3'd5, 8'((4 << 3) | k));
            rx_count = 6'(t - 1); tick(1);
            wr(3'd4, 8'h07);
            rd(3'd2, v); check($sformatf("R8 R10 rx code %0d below", k), v, 0);
            rx_count = 6'(t); tick(1);
            rd(3'd2, v); check($sformatf("R8 R10 rx code %0d at", k), v, 2);
            rx_count = '0; tick(1); wr(3'd4, 8'h07);
        end
        rd(3'd5, v); check("R10 level readback", v, (4 << 3) | 7);
    endtask

    task automatic t_tx_levels;
        int v, t;
        rx_count = '0;
        for (int k = 0; k < 8; k++) begin
            t = thr_of(k);
            wr(3'd5, 8'(k << 3));
            tx_count = 6'(DEPTH - t + 1); tick(1);
            wr(3'd4, 8'h07);
            rd(3'd2, v); check($sformatf("R9 R10 tx code %0d below", k), v, 0);
            tx_count = 6'(DEPTH - t); tick(1);
            rd(3'd2, v); check($sformatf("R9 R10 tx code %0d at", k), v, 1);
            tx_count = 6'(DEPTH); tick(1); wr(3'd4, 8'h07);
        end
        tx_hold_empty = 1'b1; tick(1);
        rd(3'd2, v); check("R11 holding flag ignored with queues on", v, 0);
        tx_hold_empty = 1'b0;
        wr(3'd6, 8'h00);
        tx_count = '0;
    endtask

    task automatic t_cts;
        int v;
        wr(3'd4, 8'h07);
        cts_in = 1'b1;
        tick(2);
        rd(3'd2, v); check("R7 not yet after two edges", v, 0);
        tick(1);
        rd(3'd2, v); check("R7 set on third edge (rise)", v, 4);
        wr(3'd1, 8'h04);
        check("R4 irq from cts", int'(irq), 1);
        tick(2);
        wr(3'd4, 8'h04);
        rd(3'd2, v); check("R7 cleared after pulse", v, 0);
        check("R4 irq drops", int'(irq), 0);
        cts_in = 1'b0; tick(3);
        rd(3'd2, v); check("R7 set on fall", v, 4);
        wr(3'd4, 8'h04); wr(3'd1, 8'h00);
    endtask

    initial begin
        int guard = 0;
        while (!done) begin
            @(posedge clk);
            guard++;
            if (guard > 100000) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: got %0d expected %0d", guard, 100000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_holding_mode();
        t_mask();
        t_rx_levels();
        t_tx_levels();
        t_cts();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule